// File: doc/BRIEF.md
# I2C Register-Access Target

This block sits on a two-wire serial bus as a 7-bit-addressed target and gives the bus master byte-wide read and write access to a register bank outside the block. SCL and SDA arrive as plain inputs and are brought into the system clock domain through two flops each. The block pulls SDA low through an open-drain enable output. The system clock must run at roughly sixteen times the SCL rate or faster, so fast-mode rates up to 400 kHz need a system clock of about 6.4 MHz or more.

The upper four bits of the device address are fixed at binary 1101. The lower three come from strap pins. After the address byte with the direction bit low, the next byte loads an 8-bit register pointer. Any further bytes in that transaction are written to the bank at the pointer, and the pointer steps after each one. A read, which has the direction bit high, returns bank contents at the pointer and steps the pointer for each byte. The pointer is kept across STOP, so a write that only sets the pointer can be followed by a separate read transaction. A repeated START may also join the two. The block also has an interrupt output whose active level is set by a polarity input.

Top module: `i2c_regport_target`

## Requirements
- R1: The block acknowledges by pulling SDA low during the ninth clock only when the seven received address bits, sent MSB first, equal binary 1101 followed by strap[2], strap[1] and strap[0]. With strap = 000 this is 0x68.
- R2: On an address mismatch, SDA stays released for the acknowledge bit and for all later bits, and no bank write occurs until the next START.
- R3: In a write (direction bit 0), the first byte after the address loads the pointer. Each later byte, received MSB first, gives one single-cycle reg_we pulse with reg_addr equal to the pointer and reg_wdata equal to the byte, and is acknowledged.
- R4: The pointer steps by one after every data byte written or read, and wraps from 0xFF to 0x00.
- R5: The pointer value survives a STOP. A later read transaction with no pointer byte starts at the stored pointer.
- R6: A repeated START restarts address reception without a STOP first.
- R7: In a read (direction bit 1), the block sends reg_rdata for the pointer MSB first. It sends the next byte after each master ACK.
- R8: A master NACK after a read byte ends output. SDA stays released until the next START or STOP.
- R9: The block changes its SDA drive only while SCL is low.
- R10: irq_o equals irq_req when irq_pol is 1, and equals the inverse of irq_req when irq_pol is 0. It takes one clock to follow a change.
- R11: After reset, SDA is released, reg_we is low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe | output | 1 | When 1, SDA is pulled low (open drain) |
| strap | input | 3 | Low bits of the device address |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | Single-cycle bank write strobe |
| reg_rdata | input | 8 | Bank contents at reg_addr |
| irq_req | input | 1 | Internal interrupt request |
| irq_pol | input | 1 | 1 = active-high irq_o, 0 = active-low |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: 8-bit pointer and data, two synchronizer stages, fixed upper address 1101 and a three-bit strap. An SCL period of 24 system clocks stays just above the sixteen-times margin. With 8 bits, the pointer wrap from 0xFF to 0x00 can be reached with a three-byte burst starting at 0xFE. Driving the strap at 000 and then 101 shows that the address match follows the pins and that the former address is then ignored.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-1:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2c_tgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl,
  input  logic         sda,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_rise,
  input  logic         sda_fall,
  input  logic [6:0]   dev_addr,
  input  logic [W-1:0] reg_rdata,
  output logic         sda_oe,
  output logic         reg_we,
  output logic [W-1:0] reg_addr,
  output logic [W-1:0] reg_wdata
);
  localparam int CW = $clog2(W + 1);

  tgt_state_e     state;
  logic           ack_ph;
  logic           rw;
  logic           mack;
  logic [CW-1:0]  bitcnt;
  logic [W-1:0]   shreg;
  logic [W-1:0]   txreg;
  logic [W-1:0]   ptr;
  logic           start_c;
  logic           stop_c;

  assign start_c  = sda_fall & scl;
  assign stop_c   = sda_rise & scl;
  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_ph    <= 1'b0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 1'b1;
      if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        ack_ph <= 1'b0;
      end else if (start_c) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_REG, ST_WR: begin
            if (!ack_ph) begin
              if (scl_rise) begin
                shreg  <= {shreg[W-2:0], sda};
                bitcnt <= bitcnt + 1'b1;
              end else if (scl_fall && bitcnt == CW'(W)) begin
                if (state == ST_DEV && shreg[W-1 -: 7] != dev_addr) begin
                  state <= ST_IDLE;
                end else begin
                  sda_oe <= 1'b1;
                  ack_ph <= 1'b1;
                  if (state == ST_DEV) rw  <= shreg[W-8];
                  if (state == ST_REG) ptr <= shreg;
                  if (state == ST_WR) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= shreg;
                  end
                end
              end
            end else if (scl_fall) begin
              sda_oe <= 1'b0;
              ack_ph <= 1'b0;
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (rw) begin
                  state  <= ST_RD;
                  txreg  <= reg_rdata;
                  sda_oe <= ~reg_rdata[W-1];
                  ptr    <= ptr + 1'b1;
                end else begin
                  state <= ST_REG;
                end
              end else if (state == ST_REG) begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (!ack_ph) begin
              if (scl_fall) begin
                if (bitcnt == CW'(W - 1)) begin
                  sda_oe <= 1'b0;
                  ack_ph <= 1'b1;
                end else begin
                  txreg  <= {txreg[W-2:0], 1'b0};
                  sda_oe <= ~txreg[W-2];
                  bitcnt <= bitcnt + 1'b1;
                end
              end
            end else begin
              if (scl_rise) begin
                mack <= ~sda;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                bitcnt <= '0;
                if (mack) begin
                  txreg  <= reg_rdata;
                  sda_oe <= ~reg_rdata[W-1];
                  ptr    <= ptr + 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the drive only starts pulling low while the synchronized clock is low
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl);

  // R2, R8: an idle target never pulls the line
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: bank write strobe lasts one cycle
  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4: pointer steps after each written byte
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> reg_addr == $past(reg_addr) + 1'b1);
endmodule

// File: rtl/i2c_irq_drive.sv
module i2c_irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic irq_pol,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= ~irq_pol;
    else     irq_o <= irq_pol ? irq_req : ~irq_req;
  end

  // R10: output follows request with the selected level after one clock
  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == ($past(irq_pol) ? $past(irq_req) : ~$past(irq_req)));
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target #(
  parameter int                 W           = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] DEV_HI      = 'b1101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic [W-1:0]       reg_addr,
  output logic [W-1:0]       reg_wdata,
  output logic               reg_we,
  input  logic [W-1:0]       reg_rdata,
  input  logic               irq_req,
  input  logic               irq_pol,
  output logic               irq_o
);
  logic [1:0] lvl, rise, fall;
  logic [6:0] dev_addr;

  assign dev_addr = {DEV_HI, strap};

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sda_i, scl_i}),
    .dout (lvl),
    .rise (rise),
    .fall (fall)
  );

  i2c_target_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .scl       (lvl[0]),
    .sda       (lvl[1]),
    .scl_rise  (rise[0]),
    .scl_fall  (fall[0]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .dev_addr  (dev_addr),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  i2c_irq_drive u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_pol (irq_pol),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/i2c_regport_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_target_tb_top;
  localparam int Q = 6;
  localparam logic [15:0] VEC [6] = '{16'h00AA, 16'h1355, 16'h7F01,
                                      16'h80FE, 16'hC33C, 16'h2D00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [2:0] strap = 3'b000;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_we;
  logic irq_req = 1'b0, irq_pol = 1'b1, irq_o;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 256; k++) mem[k] <= 8'(k) ^ 8'h5A;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  i2c_regport_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_pol(irq_pol), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); acked = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_bus; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] dev7, input logic [7:0] p, input string req);
    bit a;
    bus_start();
    send_byte({dev7[6:0], 1'b0}, a); chk(a, req, a, 1);
    send_byte(p, a);                 chk(a, req, a, 1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(reg_we == 1'b0, "R11 no write", reg_we, 0);
    chk(irq_o == 1'b0, "R10 inactive high-pol", irq_o, 0);
    // R11, R7: pointer starts at 0x00, bank init k^0x5A
    bus_start();
    send_byte(8'hD1, a); chk(a, "R1 addr 0x68 acked", a, 1);
    recv_byte(1'b0, d);  chk(d == 8'h5A, "R11 R7 read at ptr 0", d, 8'h5A);
    bus_stop();

    // Vector walk: R3 write, R5 separate pointer set, R7 read
    foreach (VEC[n]) begin
      set_ptr(8'h68, VEC[n][15:8], "R3 ack");
      send_byte(VEC[n][7:0], a); chk(a, "R3 data ack", a, 1);
      bus_stop();
      set_ptr(8'h68, VEC[n][15:8], "R5 ack");
      bus_stop();
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, d);
      bus_stop();
      chk(d == VEC[n][7:0], "R5 R7 readback", d, VEC[n][7:0]);
    end

    // R2: mismatched address is not acknowledged and writes nothing
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R2 no ack addr", a, 0);
    send_byte(8'h10, a); chk(!a, "R2 no ack byte", a, 0);
    send_byte(8'h99, a); chk(!a, "R2 no ack data", a, 0);
    bus_stop();
    set_ptr(8'h68, 8'h10, "R2 ack");
    bus_stop();
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h4A, "R2 bank untouched", d, 8'h4A);

    // R4 wrap burst, R6 repeated start, R8 NACK release
    set_ptr(8'h68, 8'hFE, "R4 ack");
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a, "R4 burst ack", a, 1);
    bus_stop();
    set_ptr(8'h68, 8'hFE, "R6 ack");
    bus_start();
    send_byte(8'hD1, a); chk(a, "R6 repeated start ack", a, 1);
    recv_byte(1'b1, d);  chk(d == 8'h11, "R4 read FE", d, 8'h11);
    recv_byte(1'b1, d);  chk(d == 8'h22, "R4 read FF", d, 8'h22);
    recv_byte(1'b0, d);  chk(d == 8'h33, "R4 wrap to 00", d, 8'h33);
    recv_byte(1'b0, d);  chk(d == 8'hFF, "R8 released after NACK", d, 8'hFF);
    bus_stop();
    // R4, R5: pointer now 0x01, survives STOP
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h5B, "R5 R4 pointer kept", d, 8'h5B);

    // R1: strap pins set the low bits
    strap = 3'b101;
    wq();
    bus_start(); send_byte(8'hD0, a); bus_stop();
    chk(!a, "R1 old addr ignored", a, 0);
    bus_start(); send_byte(8'hDA, a); bus_stop();
    chk(a, "R1 strap addr 0x6D acked", a, 1);

    // R10: polarity
    irq_req = 1'b1; irq_pol = 1'b1; repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R10 active high", irq_o, 1);
    irq_pol = 1'b0; repeat (3) @(negedge clk);
    chk(irq_o == 1'b0, "R10 active low", irq_o, 0);
    irq_req = 1'b0; repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R10 idle low-pol", irq_o, 1);

    done = 1'b1;
    report();
  end
endmodule